// File: doc/BRIEF.md
# Nibble Bit Manipulation Unit

This unit carries out the single-bit instructions of a small controller whose data memory and peripheral registers are 4 bits wide. Each request picks one of four operations: force the bit to 1, force it to 0, skip if the bit is 1, or skip if the bit is 0. The target bit is located by one of four addressing forms:

- a full direct byte address,
- a short field placed in a fixed window at the top of the address space,
- a peripheral form where register L supplies both the low address bits and the bit number,
- a form where register H is the upper address nibble and an instruction nibble is the lower one.

The unit places the effective address on a combinational read port and takes the nibble back in the same cycle. One cycle later it shows a write (for set and clear) or a skip request (for the tests) on registered outputs. The memory array, instruction fetch and sequencing all sit outside the unit. When a request reads the address that the previous request is still writing, the pending nibble is forwarded, so back-to-back requests see each other's results.

Top module: `bit_manip_unit`

## Requirements
- R1: While rst_ni is low, and after reset until a request arrives, wr_en_o and skip_o are 0.
- R2: With mode_i = 0 (direct), rd_addr_o equals field_i and the bit number is bit_i.
- R3: With mode_i = 1 (short), rd_addr_o is field_i[3:0] with address bits 7..4 forced to 1 (range F0h..FFh), and the bit number is bit_i.
- R4: With mode_i = 2 (L-indexed), rd_addr_o is {field_i[7:2], l_i[3:2]} and the bit number is l_i[1:0]; bit_i is not used.
- R5: With mode_i = 3 (H-offset), rd_addr_o is {h_i, field_i[3:0]} and the bit number is bit_i.
- R6: op_i = 0 (set): one cycle after the request, wr_en_o is 1, wr_addr_o is the effective address, and wr_data_o is the read nibble with the selected bit at 1 and the other three bits unchanged.
- R7: op_i = 1 (clear): same as R6, except that the selected bit is written as 0.
- R8: op_i = 2 (skip if true): one cycle after the request, skip_o is 1 exactly when the selected bit is 1, and wr_en_o is 0.
- R9: op_i = 3 (skip if false): one cycle after the request, skip_o is 1 exactly when the selected bit is 0, and wr_en_o is 0.
- R10: If a request's effective address matches the write shown on the outputs in the same cycle, the request operates on wr_data_o and not on rd_data_i.
- R11: A cycle with valid_i low gives wr_en_o = 0 and skip_o = 0 in the next cycle, and it leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 2 | 0 set, 1 clear, 2 skip if 1, 3 skip if 0 |
| mode_i | input | 2 | 0 direct, 1 short, 2 L-indexed, 3 H-offset |
| field_i | input | 8 | Address field from the instruction |
| bit_i | input | 2 | Bit number from the instruction |
| l_i | input | 4 | Register L |
| h_i | input | 4 | Register H |
| rd_addr_o | output | 8 | Effective address for the combinational read |
| rd_data_i | input | 4 | Nibble read at rd_addr_o |
| wr_en_o | output | 1 | Write strobe, one cycle after a set or clear |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 4 | Modified nibble |
| skip_o | output | 1 | Skip request, one cycle after a test that holds |

## Verification
Directed requests exercise each addressing form with field, L and H values chosen so that a wrong bit slice or a missing forced bit gives a different address. In the L-indexed form, bit_i is set to disagree with l_i[1:0], which exposes use of the wrong bit source. Set, clear and both tests are applied to nibbles that already hold the target value and to nibbles that do not. This separates a correct read-modify-write from one that writes a constant or touches neighbouring bits. Back-to-back requests to the same address, including a set followed at once by a test, show whether forwarding works. A random mix over a small address range, followed by a full comparison of memory against the model, catches stale data and writes made by idle cycles.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_CLR = 2'd1,
    OP_SKT = 2'd2,
    OP_SKF = 2'd3
  } bmu_op_e;

  typedef enum logic [1:0] {
    AM_DIR   = 2'd0,
    AM_SHORT = 2'd1,
    AM_LIDX  = 2'd2,
    AM_HOFF  = 2'd3
  } bmu_mode_e;
endpackage

// File: rtl/bmu_ea_gen.sv
module bmu_ea_gen
  import bmu_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 4,
  parameter int SHORT_W = 4,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int HALF_W = ADDR_W / 2,
  localparam int L_W    = 2 * BIT_W
) (
  input  bmu_mode_e         mode_i,
  input  logic [ADDR_W-1:0] field_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [L_W-1:0]    l_i,
  input  logic [HALF_W-1:0] h_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [BIT_W-1:0]  bit_o
);
  always_comb begin
    bit_o = bit_i;
    unique case (mode_i)
      AM_DIR:   ea_o = field_i;
      AM_SHORT: ea_o = {{(ADDR_W-SHORT_W){1'b1}}, field_i[SHORT_W-1:0]};
      AM_LIDX: begin
        ea_o  = {field_i[ADDR_W-1:BIT_W], l_i[L_W-1:BIT_W]};
        bit_o = l_i[BIT_W-1:0];
      end
      default:  ea_o = {h_i, field_i[HALF_W-1:0]};
    endcase
  end
endmodule

// File: rtl/bmu_bit_alu.sv
module bmu_bit_alu
  import bmu_pkg::*;
#(
  parameter int DATA_W = 4,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  bmu_op_e           op_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              is_wr_o,
  output logic              skip_o
);
  logic sel_val;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign data_o[i] = (bit_i == BIT_W'(i)) ? (op_i == OP_SET) : data_i[i];
  end

  assign sel_val = data_i[bit_i];
  assign is_wr_o = (op_i == OP_SET) || (op_i == OP_CLR);

  always_comb begin
    unique case (op_i)
      OP_SKT:  skip_o = sel_val;
      OP_SKF:  skip_o = ~sel_val;
      default: skip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bit_manip_unit.sv
module bit_manip_unit
  import bmu_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 4,
  parameter int SHORT_W = 4,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int HALF_W = ADDR_W / 2,
  localparam int L_W    = 2 * BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] field_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [L_W-1:0]    l_i,
  input  logic [HALF_W-1:0] h_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              skip_o
);
  logic [ADDR_W-1:0] ea;
  logic [BIT_W-1:0]  bit_sel;
  logic [DATA_W-1:0] opnd, nxt_data;
  logic              is_wr, do_skip;
  logic              wr_en_q, skip_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  bmu_ea_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_ea (
    .mode_i (bmu_mode_e'(mode_i)),
    .field_i(field_i),
    .bit_i  (bit_i),
    .l_i    (l_i),
    .h_i    (h_i),
    .ea_o   (ea),
    .bit_o  (bit_sel)
  );

  // forward the pending write to a dependent request
  assign opnd = (wr_en_q && (wr_addr_q == ea)) ? wr_data_q : rd_data_i;

  bmu_bit_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (bmu_op_e'(op_i)),
    .bit_i  (bit_sel),
    .data_i (opnd),
    .data_o (nxt_data),
    .is_wr_o(is_wr),
    .skip_o (do_skip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      skip_q    <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q   <= valid_i & is_wr;
      skip_q    <= valid_i & do_skip;
      wr_addr_q <= ea;
      wr_data_q <= nxt_data;
    end
  end

  assign rd_addr_o = ea;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign skip_o    = skip_q;

  // R8 R9
  test_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[1]) |=> !wr_en_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wr_en_o && !skip_o));

  // R6 R7
  one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[1]) |=> ($countones(wr_data_o ^ $past(opnd)) <= 1));

  // R6
  set_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0) |=> wr_data_o[$past(bit_sel)]);

  // R7
  clr_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1) |=> !wr_data_o[$past(bit_sel)]);

  // R3
  short_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) |-> (&rd_addr_o[ADDR_W-1:SHORT_W]));

  // R8 R9
  skip_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> $past(valid_i && op_i[1]));
endmodule

// File: tb/bit_manip_unit_bench.sv
`timescale 1ns/100ps
module bit_manip_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] op_i = '0, mode_i = '0, bit_i = '0;
  logic [7:0] field_i = '0;
  logic [3:0] l_i = '0, h_i = '0;
  logic [7:0] rd_addr_o, wr_addr_o;
  logic [3:0] rd_data_i, wr_data_o;
  logic       wr_en_o, skip_o;

  logic [3:0] ram [256];
  int mdl [256];
  int checks = 0, errors = 0;
  bit done = 0;
  bit prev_wr = 0;
  int prev_addr = 0;

  always #2.5 clk_i = ~clk_i;

  bit_manip_unit u_bit_manip_unit (
    .clk_i, .rst_ni, .valid_i, .op_i, .mode_i, .field_i, .bit_i, .l_i, .h_i,
    .rd_addr_o, .rd_data_i, .wr_en_o, .wr_addr_o, .wr_data_o, .skip_o
  );

  assign rd_data_i = ram[rd_addr_o];
  always @(posedge clk_i) if (wr_en_o) ram[wr_addr_o] <= wr_data_o;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_op(input bit v, input int op, input int mode, input int field,
                       input int b, input int l, input int h);
    int ea, bi, d, nd;
    bit ewr, esk, bv;
    string tg, atg;
    valid_i = v; op_i = 2'(op); mode_i = 2'(mode); field_i = 8'(field);
    bit_i = 2'(b); l_i = 4'(l); h_i = 4'(h);
    case (mode)
      0: begin ea = field; bi = b; atg = "R2"; end
      1: begin ea = 240 + field % 16; bi = b; atg = "R3"; end
      2: begin ea = (field / 4) * 4 + l / 4; bi = l % 4; atg = "R4"; end
      default: begin ea = h * 16 + field % 16; bi = b; atg = "R5"; end
    endcase
    d = mdl[ea];
    bv = ((d >> bi) & 1) == 1;
    #1;
    if (v) chk(rd_addr_o == 8'(ea), atg, int'(rd_addr_o), ea);
    ewr = v && op < 2;
    nd = (op == 0) ? (d | (1 << bi)) : (d & ~(1 << bi) & 15);
    esk = v && ((op == 2 && bv) || (op == 3 && !bv));
    if (!v) tg = "R11";
    else if (prev_wr && ea == prev_addr) tg = "R10";
    else case (op)
      0: tg = "R6";
      1: tg = "R7";
      2: tg = "R8";
      default: tg = "R9";
    endcase
    if (ewr) mdl[ea] = nd;
    prev_wr = ewr;
    prev_addr = ea;
    @(negedge clk_i);
    chk(wr_en_o == ewr, tg, int'(wr_en_o), int'(ewr));
    if (ewr) begin
      chk(wr_addr_o == 8'(ea), tg, int'(wr_addr_o), ea);
      chk(wr_data_o == 4'(nd), tg, int'(wr_data_o), nd);
    end
    chk(skip_o == esk, tg, int'(skip_o), int'(esk));
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 4'((i * 7 + 3) % 16);
      mdl[i] = (i * 7 + 3) % 16;
    end
    #12;
    chk(wr_en_o == 0 && skip_o == 0, "R1", int'({wr_en_o, skip_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(wr_en_o == 0 && skip_o == 0, "R1", int'({wr_en_o, skip_o}), 0);
    // direct form, each operation
    do_op(1, 0, 0, 8'h25, 3, 0, 0);
    do_op(1, 1, 0, 8'h40, 1, 0, 0);
    do_op(1, 2, 0, 8'h13, 0, 0, 0);
    do_op(1, 3, 0, 8'h13, 2, 0, 0);
    // short form, field upper bits must be ignored
    do_op(1, 0, 1, 8'h3A, 2, 0, 0);
    do_op(1, 2, 1, 8'h05, 1, 0, 0);
    // L-indexed, bit_i disagrees with L
    do_op(1, 1, 2, 8'hB4, 3, 4'b1001, 0);
    do_op(1, 3, 2, 8'h70, 0, 4'b0110, 0);
    // H-offset
    do_op(1, 0, 3, 8'hF6, 0, 0, 4'h9);
    do_op(1, 2, 3, 8'h02, 3, 0, 4'h5);
    // back-to-back same address (forwarding)
    do_op(1, 0, 0, 8'h88, 2, 0, 0);
    do_op(1, 2, 0, 8'h88, 2, 0, 0);
    do_op(1, 1, 0, 8'h88, 2, 0, 0);
    do_op(1, 0, 3, 8'h08, 0, 0, 4'h8);
    do_op(1, 3, 0, 8'h88, 0, 0, 0);
    // idle cycle carrying a set must not write
    do_op(0, 0, 0, 8'h50, 1, 0, 0);
    do_op(1, 2, 0, 8'h50, 1, 0, 0);
    do_op(0, 2, 0, 8'h50, 1, 0, 0);
    for (int n = 0; n < 400; n++)
      do_op(($urandom % 8) != 0, $urandom % 4, $urandom % 4,
            (($urandom % 2) ? 8'hF0 : 8'h00) | ($urandom % 4), $urandom % 4,
            $urandom % 16, ($urandom % 2) ? 15 : 0);
    do_op(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk_i);
    for (int i = 0; i < 256; i++)
      chk(int'(ram[i]) == mdl[i], "R11", int'(ram[i]), mdl[i]);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule